// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block sits beside a 32-bit processor core and serves its coprocessor move instructions. Each request carries a write/read select, a register number, an operation code and a 32-bit data word, and is presented for a single cycle with a valid strobe. Four writable 32-bit registers are held here: system control, page table base, data fault status and fault address. Two read-only words, processor identification and cache type, are fixed by parameters.

Two register numbers store nothing. A write to register 5 selects one of eight cache maintenance commands through its operation code. A write to register 6 with an operation code from 2 to 6 requests a full TLB invalidate. Both results leave the block as one-cycle pulses, because the caches and the TLB are not part of this block. An access that is not recognized raises a one-cycle error pulse and changes no state. All outputs are registered, so every response appears in the cycle after the request.

Top module: `sysctl_coproc`

## Requirements
- R1: A write with operation 0 to register 1 (system control), 2 (page table base), 3 (data fault status) or 4 (fault address) stores the data word. A later read of the same register with operation 0 returns it. Read data and the `rd_valid` strobe appear in the cycle after the read request.
- R2: A write to registers 1 to 4 with a nonzero operation code stores nothing and pulses `err_pulse`.
- R3: A write to register 5 pulses exactly one bit of `cache_cmd`, chosen by the operation code: bit 0 = 10 (clean data cache), bit 1 = 11 (clean one data line), bit 2 = 12 (invalidate data cache), bit 3 = 13 (invalidate one data line), bit 4 = 14 (flush data cache), bit 5 = 15 (flush one data line), bit 6 = 20 (invalidate instruction cache), bit 7 = 28 (invalidate both caches). Any other operation code on register 5 gives no pulse and no error.
- R4: When bit 1, 3 or 5 of `cache_cmd` pulses, `line_addr` carries the request's data word in the same cycle. At all other times `line_addr` is zero.
- R5: A write to register 6 with an operation code from 2 to 6 inclusive pulses `tlb_flush`. Any other operation code on register 6 gives no pulse and no error.
- R6: A read of register 0 returns `ID_WORD` with operation 0 and `CTYPE_WORD` with operation 1.
- R7: Every other read still pulses `rd_valid`, returns zero and pulses `err_pulse`.
- R8: A write to register 0 or to any register number of 7 or above stores nothing, pulses no command and pulses `err_pulse`.
- R9: Every output pulse lasts exactly one cycle, in the cycle after its request. Back-to-back requests give back-to-back responses. Without a request all pulse outputs are zero.
- R10: Synchronous active-high reset clears registers 1 to 4 and all outputs to zero.
- R11: At most one bit of `cache_cmd` is set at a time, and `err_pulse` never coincides with a cache command or a TLB pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Single-cycle request strobe |
| req_write | input | 1 | 1 = move to coprocessor, 0 = move from coprocessor |
| req_reg | input | REGN_W | Coprocessor register number |
| req_op | input | OP_W | Operation code |
| req_wdata | input | DATA_W | Write data, also the line address for line commands |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | DATA_W | Read response data |
| cache_cmd | output | 8 | One-hot cache maintenance pulse |
| line_addr | output | DATA_W | Line address for line commands |
| tlb_flush | output | 1 | Full TLB invalidate pulse |
| err_pulse | output | 1 | Unrecognized access pulse |

## Verification
The bound assertions check on every cycle that `cache_cmd` is one-hot or zero and that the error pulse never coincides with a command. They also check that each pulse or read response follows a request of the matching kind, that a line address appears only with a line command, and that a failed read returns zero. Only the bench's scenarios can show the decode itself. It sweeps every register number against every operation code, for both writes and reads, and compares each outcome with a model computed from the requirements. Its read-back sweep shows that stored values survive the rejected writes that followed them. Reset clearing, and back-to-back pulses on consecutive cycles, are also covered by dedicated scenarios.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int NUM_RW  = 4;
  localparam int NUM_CMD = 8;
  localparam logic [NUM_CMD-1:0] LINE_MASK = 8'b0010_1010;

  typedef struct packed {
    logic [NUM_RW-1:0]  wr_en;
    logic [NUM_RW-1:0]  rd_reg;
    logic               rd_id;
    logic               rd_ct;
    logic               rd;
    logic [NUM_CMD-1:0] cmd;
    logic               line;
    logic               tlb;
    logic               err;
  } dec_t;

  function automatic int cmd_op(input int bit_idx);
    case (bit_idx)
      0: return 10;
      1: return 11;
      2: return 12;
      3: return 13;
      4: return 14;
      5: return 15;
      6: return 20;
      default: return 28;
    endcase
  endfunction
endpackage

// File: rtl/cp_decode.sv
module cp_decode #(
  parameter int REGN_W = 4,
  parameter int OP_W   = 5
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [REGN_W-1:0] req_reg,
  input  logic [OP_W-1:0]   req_op,
  output sysctl_pkg::dec_t  dec
);
  import sysctl_pkg::*;

  localparam logic [REGN_W-1:0] REG_ID   = REGN_W'(0);
  localparam logic [REGN_W-1:0] REG_CMD  = REGN_W'(5);
  localparam logic [REGN_W-1:0] REG_TLB  = REGN_W'(6);
  localparam logic [OP_W-1:0]   OP_ZERO  = '0;
  localparam logic [OP_W-1:0]   OP_ONE   = OP_W'(1);
  localparam logic [OP_W-1:0]   TLB_LO   = OP_W'(2);
  localparam logic [OP_W-1:0]   TLB_HI   = OP_W'(6);

  logic wr, rdq;
  logic [NUM_RW-1:0] hit_rw;
  logic [NUM_CMD-1:0] cmd_hit;
  logic known_wr;

  assign wr  = req_valid &  req_write;
  assign rdq = req_valid & ~req_write;

  genvar i;
  generate
    for (i = 0; i < NUM_RW; i++) begin : g_rw
      assign hit_rw[i] = (req_reg == REGN_W'(i + 1));
    end
    for (i = 0; i < NUM_CMD; i++) begin : g_cmd
      assign cmd_hit[i] = (req_op == OP_W'(cmd_op(i)));
    end
  endgenerate

  always_comb begin
    dec        = '0;
    dec.rd     = rdq;
    dec.wr_en  = (wr && req_op == OP_ZERO) ? hit_rw : '0;
    dec.rd_reg = (rdq && req_op == OP_ZERO) ? hit_rw : '0;
    dec.rd_id  = rdq && req_reg == REG_ID && req_op == OP_ZERO;
    dec.rd_ct  = rdq && req_reg == REG_ID && req_op == OP_ONE;
    dec.cmd    = (wr && req_reg == REG_CMD) ? cmd_hit : '0;
    dec.line   = |(dec.cmd & LINE_MASK);
    dec.tlb    = wr && req_reg == REG_TLB && req_op >= TLB_LO && req_op <= TLB_HI;
    known_wr   = ((|hit_rw) && req_op == OP_ZERO) || req_reg == REG_CMD || req_reg == REG_TLB;
    dec.err    = (wr && !known_wr) ||
                 (rdq && !(dec.rd_id || dec.rd_ct || (|dec.rd_reg)));
  end
endmodule

// File: rtl/cp_regbank.sv
module cp_regbank #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] ID_WORD    = '0,
  parameter logic [DATA_W-1:0] CTYPE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  sysctl_pkg::dec_t  dec,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  import sysctl_pkg::*;

  logic [DATA_W-1:0] regs [NUM_RW];
  logic [DATA_W-1:0] rd_mux;

  genvar i;
  generate
    for (i = 0; i < NUM_RW; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)               regs[i] <= '0;
        else if (dec.wr_en[i]) regs[i] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (dec.rd_id) rd_mux = ID_WORD;
    if (dec.rd_ct) rd_mux = CTYPE_WORD;
    for (int k = 0; k < NUM_RW; k++)
      if (dec.rd_reg[k]) rd_mux = regs[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= dec.rd;
      rd_data  <= rd_mux;
    end
  end
endmodule

// File: rtl/cp_cmdgen.sv
module cp_cmdgen #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  sysctl_pkg::dec_t  dec,
  input  logic [DATA_W-1:0] wdata,
  output logic [sysctl_pkg::NUM_CMD-1:0] cache_cmd,
  output logic [DATA_W-1:0] line_addr,
  output logic              tlb_flush,
  output logic              err_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cache_cmd <= '0;
      line_addr <= '0;
      tlb_flush <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      cache_cmd <= dec.cmd;
      line_addr <= dec.line ? wdata : '0;
      tlb_flush <= dec.tlb;
      err_pulse <= dec.err;
    end
  end
endmodule

// File: rtl/sysctl_coproc.sv
module sysctl_coproc #(
  parameter int REGN_W = 4,
  parameter int OP_W   = 5,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] ID_WORD    = 32'h4D11_0863,
  parameter logic [DATA_W-1:0] CTYPE_WORD = 32'h0D15_2152
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [REGN_W-1:0] req_reg,
  input  logic [OP_W-1:0]   req_op,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        cache_cmd,
  output logic [DATA_W-1:0] line_addr,
  output logic              tlb_flush,
  output logic              err_pulse
);
  sysctl_pkg::dec_t dec;

  cp_decode #(.REGN_W(REGN_W), .OP_W(OP_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write),
    .req_reg(req_reg), .req_op(req_op), .dec(dec)
  );

  cp_regbank #(.DATA_W(DATA_W), .ID_WORD(ID_WORD), .CTYPE_WORD(CTYPE_WORD)) u_bank (
    .clk(clk), .rst(rst), .dec(dec), .wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  cp_cmdgen #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst(rst), .dec(dec), .wdata(req_wdata),
    .cache_cmd(cache_cmd), .line_addr(line_addr),
    .tlb_flush(tlb_flush), .err_pulse(err_pulse)
  );
endmodule

// File: rtl/cp_chk.sv
module cp_chk #(
  parameter int REGN_W = 4,
  parameter int OP_W   = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [REGN_W-1:0] req_reg,
  input logic [OP_W-1:0]   req_op,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [7:0]        cache_cmd,
  input logic [DATA_W-1:0] line_addr,
  input logic              tlb_flush,
  input logic              err_pulse
);
  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cache_cmd)); // R11
  AST_ERR_ALONE: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (cache_cmd == 8'd0 && !tlb_flush)); // R11
  AST_CMD_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (|cache_cmd) |-> $past(req_valid && req_write && req_reg == REGN_W'(5))); // R3
  AST_TLB_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    tlb_flush |-> $past(req_valid && req_write && req_reg == REGN_W'(6)
                        && req_op >= OP_W'(2) && req_op <= OP_W'(6))); // R5
  AST_LINE_ONLY_WITH_CMD: assert property (@(posedge clk) disable iff (rst)
    (line_addr != '0) |-> (|(cache_cmd & 8'b0010_1010))); // R4
  AST_RD_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(req_valid && !req_write)); // R9
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && err_pulse) |-> (rd_data == '0)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rd_valid && !err_pulse && !tlb_flush && cache_cmd == 8'd0)); // R9
endmodule

bind sysctl_coproc cp_chk #(.REGN_W(REGN_W), .OP_W(OP_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_sysctl_coproc.sv
`timescale 1ns/1ps
module sim_sysctl_coproc;
  localparam int REGN_W = 4;
  localparam int OP_W   = 5;
  localparam int DATA_W = 32;
  localparam logic [31:0] IDW = 32'h4D11_0863;
  localparam logic [31:0] CTW = 32'h0D15_2152;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [REGN_W-1:0] req_reg = '0;
  logic [OP_W-1:0]   req_op = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic rd_valid, tlb_flush, err_pulse;
  logic [DATA_W-1:0] rd_data, line_addr;
  logic [7:0] cache_cmd;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] model [1:4];

  always #4 clk = ~clk;

  sysctl_coproc #(.REGN_W(REGN_W), .OP_W(OP_W), .DATA_W(DATA_W),
                  .ID_WORD(IDW), .CTYPE_WORD(CTW)) u0 (.*);

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_bit(input int r, input int o);
    if (r != 5) return -1;
    case (o)
      10: return 0; 11: return 1; 12: return 2; 13: return 3;
      14: return 4; 15: return 5; 20: return 6; 28: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [127:0] out_vec();
    return {rd_valid, rd_data, cache_cmd, line_addr, tlb_flush, err_pulse};
  endfunction

  function automatic logic [127:0] pack(input logic rv, input logic [31:0] rdd, input logic [7:0] cc,
                                        input logic [31:0] la, input logic tf, input logic er);
    return {rv, rdd, cc, la, tf, er};
  endfunction

  task automatic drive(input logic w, input int r, input int o, input logic [31:0] d);
    req_valid = 1'b1; req_write = w;
    req_reg = REGN_W'(r); req_op = OP_W'(o); req_wdata = d;
  endtask

  task automatic do_write(input int r, input int o, input logic [31:0] d);
    int b; logic [7:0] cc; logic [31:0] la; logic tf, er; string tag;
    @(negedge clk); drive(1'b1, r, o, d);
    @(negedge clk); req_valid = 1'b0;
    b  = exp_bit(r, o);
    cc = (b >= 0) ? 8'(1 << b) : 8'd0;
    la = (b == 1 || b == 3 || b == 5) ? d : 32'd0;
    tf = (r == 6 && o >= 2 && o <= 6);
    er = (r == 0 || r >= 7 || (r >= 1 && r <= 4 && o != 0));
    if (r >= 1 && r <= 4 && o == 0) model[r] = d;
    if (r == 5)      tag = "R3/R4 cache command";
    else if (r == 6) tag = "R5 tlb";
    else if (r >= 1 && r <= 4) tag = (o == 0) ? "R1 store" : "R2 bad op";
    else             tag = "R8 bad register";
    check(tag, out_vec(), pack(1'b0, 32'd0, cc, la, tf, er));
    @(negedge clk);
    check("R9 pulse width", out_vec(), '0);
  endtask

  task automatic do_read(input int r, input int o);
    logic [31:0] ev; logic er;
    @(negedge clk); drive(1'b0, r, o, 32'hFFFF_FFFF);
    @(negedge clk); req_valid = 1'b0;
    er = 1'b0;
    if (r == 0 && o == 0) ev = IDW;
    else if (r == 0 && o == 1) ev = CTW;
    else if (r >= 1 && r <= 4 && o == 0) ev = model[r];
    else begin ev = 32'd0; er = 1'b1; end
    check(er ? "R7 bad read" : (r == 0 ? "R6 id read" : "R1 readback"),
          out_vec(), pack(1'b1, ev, 8'd0, 32'd0, 1'b0, er));
  endtask

  initial begin
    for (int k = 1; k <= 4; k++) model[k] = 32'd0;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", out_vec(), '0);
    rst = 1'b0;
    for (int r = 1; r <= 4; r++) do_read(r, 0);            // R10 cleared
    for (int r = 0; r < 16; r++)
      for (int o = 0; o < 32; o++)
        do_write(r, o, 32'hC0DE_0005 ^ 32'(r << 12) ^ 32'(o << 3));
    for (int r = 0; r < 16; r++)
      for (int o = 0; o < 32; o++)
        do_read(r, o);
    // R9 back-to-back commands
    @(negedge clk); drive(1'b1, 5, 10, 32'h11);
    @(negedge clk); drive(1'b1, 5, 28, 32'h22);
    check("R9 back-to-back first", out_vec(), pack(1'b0, 32'd0, 8'h01, 32'd0, 1'b0, 1'b0));
    @(negedge clk); req_valid = 1'b0;
    check("R9 back-to-back second", out_vec(), pack(1'b0, 32'd0, 8'h80, 32'd0, 1'b0, 1'b0));
    // R10 reset clears stored registers
    for (int r = 1; r <= 4; r++) do_write(r, 0, 32'hABCD_0000 + 32'(r));
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int k = 1; k <= 4; k++) model[k] = 32'd0;
    for (int r = 1; r <= 4; r++) do_read(r, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule